// File: doc/BRIEF.md
# Result Hold Buffer with Read-Once Tracking

This block sits between a cipher engine and the register read path. The engine hands over a 128-bit result together with its kind (plaintext, ciphertext or tag) and a tag-check outcome. The block stores the result as four 32-bit words that software fetches one at a time through a word index. Each word carries its own unread flag. A result counts as consumed only after every word has been fetched at least once, in any order.

While a mandatory result is still unconsumed, the block refuses a new result from the engine and raises a stall towards it, unless the overwrite policy input is set. With the overwrite policy set, a new result replaces the old one at once. Some results need not be read, such as the tag after a decryption, where the engine already reports the comparison outcome. The engine marks these as optional: they are shown and tracked like any other result but never hold the engine off. The kind indicator drops to "none" once every word of the current result has been fetched.

Top module: `out_read_tracker`

## Requirements
- R1: After reset the kind indicator is 000, the tag status is 00, the stall is low and every word reads as zero.
- R2: A result is accepted on a clock edge where `res_valid_i` is high and `stall_o` is low. From the next cycle, word i reads as bits [32i+31:32i] of that result and the kind indicator shows its kind.
- R3: A fetch with `rd_en_i` high marks only the addressed word as read. Repeated fetches of the same word do not mark any other word, and the four words may be fetched in any order.
- R4: With `force_ovr_i` at 0 and a mandatory result holding at least one unread word, `stall_o` equals `res_valid_i`, and the offered result is not taken: the stored words and the kind indicator keep their values.
- R5: The stall drops in the cycle after the fetch of the last unread word, and the waiting result is accepted at the following edge.
- R6: With `force_ovr_i` at 1, `stall_o` stays low and an offered result replaces unread data at the next edge.
- R7: The kind indicator is 001 for plaintext, 010 for ciphertext, 100 for tag and 000 for none, and any other offered kind code is stored as 000. It returns to 000 in the cycle after the last unread word of the current result is fetched.
- R8: The tag status is loaded with each accepted result: 01 for match, 10 for mismatch, 00 for not computed. An offered 11 is stored as 10, so 11 never appears on the output.
- R9: A result offered with `res_opt_i` at 1 is never a reason to stall. It is still shown and tracked until its words are fetched or it is replaced.
- R10: Cycles with `rd_en_i` at 0 mark no word as read, whatever the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| force_ovr_i | input | 1 | 1: new results overwrite unread data; 0: stall instead |
| res_valid_i | input | 1 | Engine offers a result |
| res_data_i | input | 128 | Result value, word i in bits [32i+31:32i] |
| res_kind_i | input | 3 | Result kind code |
| res_tag_i | input | 2 | Tag comparison outcome for this result |
| res_opt_i | input | 1 | Result need not be read before the next one |
| stall_o | output | 1 | Offered result is held off |
| rd_en_i | input | 1 | Software fetch strobe |
| rd_idx_i | input | 2 | Index of the word fetched |
| rd_data_o | output | 32 | Word selected by `rd_idx_i` |
| out_kind_o | output | 3 | Kind of the stored result, 000 when consumed |
| tag_status_o | output | 2 | Tag comparison status |

## Verification
The bench fetches the words out of order and fetches one word twice. A design that counted fetches instead of tracking each word would then drop the stall and the kind indicator early. It keeps a result offered while words remain unread, then checks that the stall falls exactly one cycle after the final fetch and that the old words are still intact during the wait. A design that let a stalled result through or released one cycle late would show the wrong data or stall timing. It also checks an overwrite with unread data under the force policy, an optional result followed straight away by a new one, an illegal 11 tag code, and index changes with the strobe low. Each of these exposes a design that stalls wrongly, leaks the illegal code or marks words without a strobe.

// File: rtl/ort_pkg.sv
package ort_pkg;

   typedef enum logic [2:0] {
      KIND_NONE   = 3'b000,
      KIND_PLAIN  = 3'b001,
      KIND_CIPHER = 3'b010,
      KIND_TAG    = 3'b100
   } out_kind_e;

   typedef enum logic [1:0] {
      TAG_PENDING  = 2'b00,
      TAG_MATCH    = 2'b01,
      TAG_MISMATCH = 2'b10
   } tag_stat_e;

   // any unknown kind code collapses to none
   function automatic out_kind_e kind_clean(input logic [2:0] code);
      case (code)
         3'b001:  kind_clean = KIND_PLAIN;
         3'b010:  kind_clean = KIND_CIPHER;
         3'b100:  kind_clean = KIND_TAG;
         default: kind_clean = KIND_NONE;
      endcase
   endfunction

   // the illegal code is treated as a failed comparison
   function automatic tag_stat_e tag_clean(input logic [1:0] code);
      case (code)
         2'b00:   tag_clean = TAG_PENDING;
         2'b01:   tag_clean = TAG_MATCH;
         default: tag_clean = TAG_MISMATCH;
      endcase
   endfunction

endpackage

// File: rtl/ort_word_bank.sv
module ort_word_bank #(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 4,
   parameter int IDX_W     = 2
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        load_i,
   input  logic [WORD_W*NUM_WORDS-1:0] load_data_i,
   input  logic                        rd_en_i,
   input  logic [IDX_W-1:0]            rd_idx_i,
   output logic [WORD_W-1:0]           rd_data_o,
   output logic [NUM_WORDS-1:0]        pend_q_o,
   output logic [NUM_WORDS-1:0]        pend_nxt_o
);

   logic [NUM_WORDS-1:0][WORD_W-1:0] words;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] val_q;
      logic              pend_q;
      logic              hit;

      assign hit = rd_en_i && (rd_idx_i == IDX_W'(w));
      assign pend_nxt_o[w] = load_i ? 1'b1 : (hit ? 1'b0 : pend_q);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            val_q  <= '0;
            pend_q <= 1'b0;
         end else begin
            pend_q <= pend_nxt_o[w];
            if (load_i) val_q <= load_data_i[w*WORD_W +: WORD_W];
         end
      end

      assign words[w]    = val_q;
      assign pend_q_o[w] = pend_q;
   end

   always_comb begin
      rd_data_o = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (rd_idx_i == IDX_W'(w)) rd_data_o = words[w];
      end
   end

   // without a load, no word may become unread again
   AST_PEND_ONLY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> ((pend_q_o & ~$past(pend_q_o)) == '0)); // R3

   // a cycle without strobe and without load leaves the flags alone
   AST_NO_STROBE_NO_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_en_i && !load_i) |=> $stable(pend_q_o)); // R10

endmodule

// File: rtl/ort_stall_ctl.sv
module ort_stall_ctl #(
   parameter int NUM_WORDS = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 force_ovr_i,
   input  logic                 res_valid_i,
   input  logic                 res_opt_i,
   input  logic [NUM_WORDS-1:0] pend_q_i,
   output logic                 stall_o,
   output logic                 accept_o
);

   logic must_read_q;
   logic blocked;

   assign blocked  = !force_ovr_i && must_read_q && (|pend_q_i);
   assign stall_o  = res_valid_i && blocked;
   assign accept_o = res_valid_i && !blocked;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       must_read_q <= 1'b0;
      else if (accept_o) must_read_q <= !res_opt_i;
   end

   // an accepted result and a stall never coincide
   AST_ACCEPT_XOR_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(accept_o && stall_o)); // R4

endmodule

// File: rtl/ort_status.sv
module ort_status
   import ort_pkg::*;
#(
   parameter int NUM_WORDS = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 load_i,
   input  logic [2:0]           kind_i,
   input  logic [1:0]           tag_i,
   input  logic [NUM_WORDS-1:0] pend_nxt_i,
   output logic [2:0]           kind_o,
   output logic [1:0]           tag_o
);

   out_kind_e kind_q;
   tag_stat_e tag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         kind_q <= KIND_NONE;
         tag_q  <= TAG_PENDING;
      end else if (load_i) begin
         kind_q <= kind_clean(kind_i);
         tag_q  <= tag_clean(tag_i);
      end else if (pend_nxt_i == '0) begin
         kind_q <= KIND_NONE;
      end
   end

   assign kind_o = kind_q;
   assign tag_o  = tag_q;

   AST_TAG_NEVER_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tag_o != 2'b11); // R8

   AST_KIND_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(kind_o)); // R7

endmodule

// File: rtl/out_read_tracker.sv
module out_read_tracker #(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 4,
   localparam int DATA_W   = WORD_W * NUM_WORDS,
   localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              force_ovr_i,
   input  logic              res_valid_i,
   input  logic [DATA_W-1:0] res_data_i,
   input  logic [2:0]        res_kind_i,
   input  logic [1:0]        res_tag_i,
   input  logic              res_opt_i,
   output logic              stall_o,
   input  logic              rd_en_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [WORD_W-1:0] rd_data_o,
   output logic [2:0]        out_kind_o,
   output logic [1:0]        tag_status_o
);

   if (NUM_WORDS < 2) begin : g_bad_words
      $error("out_read_tracker: NUM_WORDS must be at least 2");
   end
   if (WORD_W < 8) begin : g_bad_width
      $error("out_read_tracker: WORD_W must be at least 8");
   end

   logic                 accept;
   logic [NUM_WORDS-1:0] pend_q;
   logic [NUM_WORDS-1:0] pend_nxt;

   ort_stall_ctl #(.NUM_WORDS(NUM_WORDS)) u_stall (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .force_ovr_i (force_ovr_i),
      .res_valid_i (res_valid_i),
      .res_opt_i   (res_opt_i),
      .pend_q_i    (pend_q),
      .stall_o     (stall_o),
      .accept_o    (accept)
   );

   ort_word_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (accept),
      .load_data_i (res_data_i),
      .rd_en_i     (rd_en_i),
      .rd_idx_i    (rd_idx_i),
      .rd_data_o   (rd_data_o),
      .pend_q_o    (pend_q),
      .pend_nxt_o  (pend_nxt)
   );

   ort_status #(.NUM_WORDS(NUM_WORDS)) u_status (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (accept),
      .kind_i     (res_kind_i),
      .tag_i      (res_tag_i),
      .pend_nxt_i (pend_nxt),
      .kind_o     (out_kind_o),
      .tag_o      (tag_status_o)
   );

   AST_FORCE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_ovr_i |-> !stall_o); // R6

   AST_STALL_NEEDS_UNREAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o |-> (|pend_q)); // R4

   AST_STALL_FREEZES_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o |=> $stable(out_kind_o) || (pend_q == '0)); // R4

   AST_DRAINED_IS_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q == '0) |-> (out_kind_o == 3'b000)); // R7

endmodule

// File: tb/out_read_tracker_tb_top.sv
module out_read_tracker_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         force_ovr = 1'b0;
   logic         res_valid = 1'b0;
   logic [127:0] res_data = '0;
   logic [2:0]   res_kind = '0;
   logic [1:0]   res_tag = '0;
   logic         res_opt = 1'b0;
   logic         stall;
   logic         rd_en = 1'b0;
   logic [1:0]   rd_idx = '0;
   logic [31:0]  rd_data;
   logic [2:0]   out_kind;
   logic [1:0]   tag_status;

   int total = 0;
   int bad = 0;

   logic [31:0] exp_q[$];
   string       req_q[$];

   always #10 clk = ~clk;

   out_read_tracker dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .force_ovr_i  (force_ovr),
      .res_valid_i  (res_valid),
      .res_data_i   (res_data),
      .res_kind_i   (res_kind),
      .res_tag_i    (res_tag),
      .res_opt_i    (res_opt),
      .stall_o      (stall),
      .rd_en_i      (rd_en),
      .rd_idx_i     (rd_idx),
      .rd_data_o    (rd_data),
      .out_kind_o   (out_kind),
      .tag_status_o (tag_status)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops one expected word per fetch
   always @(negedge clk) begin
      if (rd_en) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL %s: actual=%0h expected=none", "R3", rd_data);
         end else begin
            check(req_q.pop_front(), {96'b0, rd_data}, {96'b0, exp_q.pop_front()});
         end
      end
   end

   // driver: one fetch, expectation pushed to the scoreboard
   task automatic fetch(input int idx, input logic [127:0] src, input string req);
      @(posedge clk); #1;
      rd_en  = 1'b1;
      rd_idx = 2'(idx);
      exp_q.push_back(src[idx*32 +: 32]);
      req_q.push_back(req);
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   // driver: offer a result and wait until it is taken
   task automatic offer(input logic [127:0] d, input logic [2:0] k, input logic [1:0] t,
                        input logic opt, output int stalled);
      stalled = 0;
      @(posedge clk); #1;
      res_valid = 1'b1; res_data = d; res_kind = k; res_tag = t; res_opt = opt;
      forever begin
         @(negedge clk);
         if (!stall) break;
         stalled++;
      end
      @(posedge clk); #1;
      res_valid = 1'b0;
   endtask

   localparam logic [127:0] D1 = 128'h44440004_33330003_22220002_11110001;
   localparam logic [127:0] D2 = 128'hDDDD0004_CCCC0003_BBBB0002_AAAA0001;
   localparam logic [127:0] D3 = 128'h0F0F0F0F_F0F0F0F0_12345678_9ABCDEF0;
   localparam logic [127:0] D4 = 128'h55555555_66666666_77777777_88888888;
   localparam logic [127:0] D5 = 128'hCAFE0001_CAFE0002_CAFE0003_CAFE0004;
   localparam logic [127:0] D6 = 128'hBEEF0001_BEEF0002_BEEF0003_BEEF0004;

   initial begin
      #(20 * 150000);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int st;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 kind", out_kind, 3'b000);
      check("R1 tag", tag_status, 2'b00);
      check("R1 stall", stall, 1'b0);
      check("R1 data", rd_data, 32'h0);

      // R2 load plaintext, fetch out of order
      offer(D1, 3'b001, 2'b00, 1'b0, st);
      @(negedge clk);
      check("R2 kind plain", out_kind, 3'b001);
      fetch(2, D1, "R2 w2");
      fetch(0, D1, "R2 w0");
      fetch(3, D1, "R3 w3");
      @(negedge clk);
      check("R3 kind kept before last", out_kind, 3'b001);
      fetch(1, D1, "R3 w1");
      @(negedge clk);
      check("R7 kind none after drain", out_kind, 3'b000);

      // R4/R5 stall with repeated fetch of one word
      offer(D2, 3'b010, 2'b01, 1'b0, st);
      @(negedge clk);
      check("R8 tag match", tag_status, 2'b01);
      fetch(0, D2, "R3 w0");
      fetch(0, D2, "R3 w0 again");
      fetch(1, D2, "R3 w1");
      @(posedge clk); #1;
      res_valid = 1'b1; res_data = D3; res_kind = 3'b100; res_tag = 2'b10; res_opt = 1'b0;
      @(negedge clk);
      check("R4 stall raised", stall, 1'b1);
      check("R4 kind held", out_kind, 3'b010);
      fetch(3, D2, "R4 old data kept");
      @(negedge clk);
      check("R4 still stalled", stall, 1'b1);
      @(posedge clk); #1;
      rd_en = 1'b1; rd_idx = 2'd2;
      exp_q.push_back(D2[95:64]); req_q.push_back("R5 last word");
      @(negedge clk);
      check("R5 stall in fetch cycle", stall, 1'b1);
      @(posedge clk); #1;
      rd_en = 1'b0;
      @(negedge clk);
      check("R5 stall drops next cycle", stall, 1'b0);
      @(posedge clk); #1;
      res_valid = 1'b0;
      @(negedge clk);
      check("R5 accepted kind tag", out_kind, 3'b100);
      check("R8 tag mismatch", tag_status, 2'b10);

      // R6 overwrite unread data, illegal tag code
      force_ovr = 1'b1;
      offer(D4, 3'b001, 2'b11, 1'b0, st);
      check("R6 no stall cycles", st, 0);
      @(negedge clk);
      check("R8 illegal tag stored as mismatch", tag_status, 2'b10);
      check("R6 kind replaced", out_kind, 3'b001);
      fetch(3, D4, "R6 w3 new");
      force_ovr = 1'b0;
      fetch(0, D4, "R6 w0 new");
      fetch(1, D4, "R6 w1 new");

      // R10 strobe low with index changes
      @(posedge clk); #1; rd_idx = 2'd2;
      @(posedge clk); #1; rd_idx = 2'd0;
      @(negedge clk);
      check("R10 kind still plain", out_kind, 3'b001);
      fetch(2, D4, "R10 w2");
      @(negedge clk);
      check("R7 drained after force", out_kind, 3'b000);

      // R9 optional result then immediate mandatory one
      offer(D5, 3'b100, 2'b01, 1'b1, st);
      @(negedge clk);
      check("R9 optional shown", out_kind, 3'b100);
      fetch(1, D5, "R9 optional w1");
      offer(D6, 3'b010, 2'b00, 1'b0, st);
      check("R9 no stall on optional", st, 0);
      @(negedge clk);
      check("R9 replaced kind", out_kind, 3'b010);
      check("R8 not computed", tag_status, 2'b00);
      for (int i = 0; i < 4; i++) fetch(3 - i, D6, "R2 w D6");
      @(negedge clk);
      check("R7 final none", out_kind, 3'b000);
      check("R5 no stall idle", stall, 1'b0);

      repeat (2) @(posedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule